// File: doc/BRIEF.md
# Multi-Lane Vector Arithmetic Unit

This block runs one integer vector instruction at a time against a small on-block file of vector registers. An instruction names an operation (wrapping add or wrapping multiply), a form (element-by-element between two registers, or every element of one register against a single scalar), two source registers, a destination register and the scalar value. Once accepted, a sequencer walks the vector in groups of `LANES` consecutive elements, one group per cycle, through `LANES` identical lane pipelines of `LAT` register stages each. No per-element control is issued from outside; the whole loop is implied by the single instruction.

Two architectural registers shape every instruction: an active-length register limiting how many leading elements take part, and a per-element write mask. Both are copied when an instruction is accepted, so later writes only affect the next instruction. Elements that are masked off or lie past the active length keep their old destination contents.

Every result group appears on a forwarding port in the cycle before it is written back, with its destination register, starting element index and per-lane write flags. A dependent consumer can start on the first group one pipeline latency after issue, rather than waiting for the entire vector. A simple load port and a combinational peek port give access to the register file for filling and inspecting it.

Top module: `vec_lane_engine`

## Requirements
- R1: After reset `busy`, `chain_valid` and `chain_en` are low, the active length equals `MVL` and all mask bits are set, so a first instruction processes every element.
- R2: In register-register form (`iss_form`=0), destination element i becomes src_a[i]+src_b[i] when `iss_op`=0 and the low 32 bits of src_a[i]*src_b[i] when `iss_op`=1, wrapping modulo 2^32.
- R3: In register-scalar form (`iss_form`=1), destination element i becomes src_a[i] combined with `iss_scalar` by the same operation encoding as R2.
- R4: With the accepting clock edge counted as edge 0, group k (elements k*LANES to k*LANES+LANES-1) is presented on the forwarding port in the cycle after edge LAT+k, with `chain_base`=k*LANES, `chain_dst` the destination and lane l of `chain_data` (bits l*32 up to l*32+31) holding element k*LANES+l.
- R5: `busy` rises in the cycle after an accepted instruction and falls in the cycle after edge LAT+ceil(VL/LANES); the last group is written into the register file at that edge.
- R6: Only elements with index below the active length VL are written, and the instruction takes ceil(VL/LANES) groups; a write to `vl_wdata` of 0 or of more than `MVL` leaves the length unchanged.
- R7: Bit i of `mask_wdata` is the write enable of element i; a clear bit keeps the old destination value, and `chain_en` bit l is set exactly when lane l's element is written.
- R8: An instruction presented while `busy` is high is dropped: it produces no forwarded group and changes no register.
- R9: Length and mask writes made while an instruction runs do not affect it and take effect from the next accepted instruction.
- R10: A destination equal to a source register is handled in place: every element reads its pre-instruction source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Instruction present; accepted when `busy` is low |
| iss_op | input | 1 | 0 add, 1 multiply |
| iss_form | input | 1 | 0 register-register, 1 register-scalar |
| iss_src_a | input | $clog2(NREGS) | First source register |
| iss_src_b | input | $clog2(NREGS) | Second source register (register-register form) |
| iss_dst | input | $clog2(NREGS) | Destination register |
| iss_scalar | input | 32 | Scalar operand (register-scalar form) |
| vl_we | input | 1 | Active-length write strobe |
| vl_wdata | input | $clog2(MVL+1) | New active length, legal 1..MVL |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | MVL | New mask, bit i for element i |
| ld_we | input | 1 | Register file load strobe |
| ld_reg | input | $clog2(NREGS) | Load register |
| ld_idx | input | $clog2(MVL) | Load element |
| ld_data | input | 32 | Load value |
| peek_reg | input | $clog2(NREGS) | Peek register |
| peek_idx | input | $clog2(MVL) | Peek element |
| peek_data | output | 32 | Peeked value, combinational |
| busy | output | 1 | Instruction in progress |
| chain_valid | output | 1 | A result group is on the forwarding port |
| chain_dst | output | $clog2(NREGS) | Destination of the group |
| chain_base | output | $clog2(MVL) | Index of the group's first element |
| chain_en | output | LANES | Per-lane write flags |
| chain_data | output | LANES*32 | Per-lane results |

## Verification
Every result has a fixed due cycle counted from the accepting edge: `busy` high at the first falling edge afterwards, group k on the forwarding port at the falling edge after edge LAT+k, `busy` low and all groups written at the falling edge after edge LAT+ceil(VL/LANES). The bench drives on falling edges and, after each issue, steps falling edge by falling edge, comparing `busy`, `chain_valid`, base, destination, write flags and lane data against the value due in that exact cycle, including cycles where nothing may appear. After each instruction the whole register file is peeked and compared against a model updated from the requirements, which catches writes outside the length, through cleared mask bits, or from a dropped instruction.

// File: rtl/vle_pkg.sv
// Shared types and the element operation for the vector lane engine.
// Assumes 32-bit integer elements; arithmetic wraps, no flags.
package vle_pkg;
    localparam int ELEM_W = 32;

    typedef enum logic {
        VOP_ADD = 1'b0,
        VOP_MUL = 1'b1
    } vop_e;

    // Apply one element operation, keeping the low ELEM_W bits.
    function automatic logic [ELEM_W-1:0] vop_apply(vop_e op,
                                                    logic [ELEM_W-1:0] a,
                                                    logic [ELEM_W-1:0] b);
        logic [ELEM_W-1:0] r;
        if (op == VOP_MUL) r = a * b;
        else               r = a + b;
        return r;
    endfunction
endpackage

// File: rtl/vle_regfile.sv
// Vector register file: NREGS registers of MVL elements.
// Two group-wide read ports (LANES consecutive elements each), one
// group-wide masked write port, one single-element load port and one
// single-element peek port. Assumes MVL is a multiple of LANES so a
// group never crosses the end of a register. Storage has no reset.
module vle_regfile #(
    parameter int NREGS = 8,
    parameter int MVL   = 8,
    parameter int LANES = 2,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic [$clog2(NREGS)-1:0] ra_reg,
    input  logic [$clog2(NREGS)-1:0] rb_reg,
    input  logic [$clog2(MVL)-1:0]   rd_base,
    output logic [W-1:0]             ra_data [LANES],
    output logic [W-1:0]             rb_data [LANES],
    input  logic                     wb_valid,
    input  logic [$clog2(NREGS)-1:0] wb_reg,
    input  logic [$clog2(MVL)-1:0]   wb_base,
    input  logic [LANES-1:0]         wb_en,
    input  logic [W-1:0]             wb_data [LANES],
    input  logic                     ld_we,
    input  logic [$clog2(NREGS)-1:0] ld_reg,
    input  logic [$clog2(MVL)-1:0]   ld_idx,
    input  logic [W-1:0]             ld_data,
    input  logic [$clog2(NREGS)-1:0] peek_reg,
    input  logic [$clog2(MVL)-1:0]   peek_idx,
    output logic [W-1:0]             peek_data
);
    localparam int IW = $clog2(MVL);

    logic [W-1:0] mem [NREGS][MVL];

    // Store loaded elements and written-back result groups.
    always_ff @(posedge clk) begin
        if (ld_we) mem[ld_reg][ld_idx] <= ld_data;
        for (int l = 0; l < LANES; l++) begin
            if (wb_valid && wb_en[l]) mem[wb_reg][wb_base + IW'(l)] <= wb_data[l];
        end
    end

    // Read one operand group from each source register.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            ra_data[l] = mem[ra_reg][rd_base + IW'(l)];
            rb_data[l] = mem[rb_reg][rd_base + IW'(l)];
        end
    end

    assign peek_data = mem[peek_reg][peek_idx];
endmodule

// File: rtl/vle_lane.sv
// One arithmetic lane: computes the element operation in its first
// stage and carries the result through LAT register stages in total.
// Assumes LAT >= 1. Data stages carry no reset; validity is tracked
// by the control pipeline in the top module.
module vle_lane #(
    parameter int W   = 32,
    parameter int LAT = 3
) (
    input  logic           clk,
    input  vle_pkg::vop_e  in_op,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    output logic [W-1:0]   out_res
);
    logic [W-1:0] stg [LAT];

    // First stage: evaluate the operation.
    always_ff @(posedge clk) begin
        stg[0] <= vle_pkg::vop_apply(in_op, in_a, in_b);
    end

    // Remaining stages: plain delay to match the configured latency.
    for (genvar s = 1; s < LAT; s++) begin : g_delay
        always_ff @(posedge clk) begin
            stg[s] <= stg[s-1];
        end
    end

    assign out_res = stg[LAT-1];
endmodule

// File: rtl/vle_seq.sv
// Instruction sequencer: holds the active-length and mask registers,
// accepts one instruction when the unit is idle, snapshots length and
// mask, and steps a group base through the vector LANES elements per
// cycle, producing per-lane write enables. Assumes MVL % LANES == 0.
module vle_seq #(
    parameter int MVL   = 8,
    parameter int LANES = 2,
    parameter int NREGS = 8,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vl_we,
    input  logic [$clog2(MVL+1)-1:0] vl_wdata,
    input  logic                     mask_we,
    input  logic [MVL-1:0]           mask_wdata,
    input  logic                     iss_valid,
    input  vle_pkg::vop_e            iss_op,
    input  logic                     iss_form,
    input  logic [$clog2(NREGS)-1:0] iss_src_a,
    input  logic [$clog2(NREGS)-1:0] iss_src_b,
    input  logic [$clog2(NREGS)-1:0] iss_dst,
    input  logic [W-1:0]             iss_scalar,
    input  logic                     pipe_busy,
    output logic                     active,
    output logic [$clog2(MVL)-1:0]   g_base,
    output vle_pkg::vop_e            g_op,
    output logic                     g_form,
    output logic [$clog2(NREGS)-1:0] g_sa,
    output logic [$clog2(NREGS)-1:0] g_sb,
    output logic [$clog2(NREGS)-1:0] g_dst,
    output logic [W-1:0]             g_scalar,
    output logic [LANES-1:0]         g_en
);
    localparam int IW  = $clog2(MVL);
    localparam int VLW = $clog2(MVL+1);

    logic [VLW-1:0] vl_q, s_vl;
    logic [MVL-1:0] mask_q, s_mask;
    logic [IW-1:0]  base_q, last_q;
    logic           accept;

    assign accept = iss_valid && !active && !pipe_busy;

    // Architectural length and mask; illegal lengths are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q   <= VLW'(MVL);
            mask_q <= '1;
        end else begin
            if (vl_we && vl_wdata != '0 && vl_wdata <= VLW'(MVL)) vl_q <= vl_wdata;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    // Walk the group base from 0 to the last group of the snapshot length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base_q <= '0;
            last_q <= '0;
        end else if (accept) begin
            active <= 1'b1;
            base_q <= '0;
            last_q <= IW'(((vl_q - VLW'(1)) / VLW'(LANES)) * VLW'(LANES));
        end else if (active) begin
            if (base_q == last_q) active <= 1'b0;
            else                  base_q <= base_q + IW'(LANES);
        end
    end

    // Capture the instruction fields, length and mask on acceptance.
    always_ff @(posedge clk) begin
        if (accept) begin
            g_op     <= iss_op;
            g_form   <= iss_form;
            g_sa     <= iss_src_a;
            g_sb     <= iss_src_b;
            g_dst    <= iss_dst;
            g_scalar <= iss_scalar;
            s_vl     <= vl_q;
            s_mask   <= mask_q;
        end
    end

    // Per-lane write enable: inside the length and mask bit set.
    always_comb begin
        logic [VLW-1:0] idx;
        for (int l = 0; l < LANES; l++) begin
            idx     = VLW'(base_q) + VLW'(l);
            g_en[l] = active && (idx < s_vl) && s_mask[idx[IW-1:0]];
        end
    end

    assign g_base = base_q;
endmodule

// File: rtl/vec_lane_engine.sv
// Multi-lane vector arithmetic unit. Accepts one vector instruction
// when idle, streams LANES elements per cycle through LANES lanes of
// LAT stages, forwards each finished group on the chain port and
// writes it back one edge later under length and mask control.
// Assumes MVL % LANES == 0, LAT >= 1 and register numbers < NREGS.
module vec_lane_engine #(
    parameter int MVL   = 8,
    parameter int LANES = 2,
    parameter int NREGS = 8,
    parameter int LAT   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         iss_valid,
    input  logic                         iss_op,
    input  logic                         iss_form,
    input  logic [$clog2(NREGS)-1:0]     iss_src_a,
    input  logic [$clog2(NREGS)-1:0]     iss_src_b,
    input  logic [$clog2(NREGS)-1:0]     iss_dst,
    input  logic [31:0]                  iss_scalar,
    input  logic                         vl_we,
    input  logic [$clog2(MVL+1)-1:0]     vl_wdata,
    input  logic                         mask_we,
    input  logic [MVL-1:0]               mask_wdata,
    input  logic                         ld_we,
    input  logic [$clog2(NREGS)-1:0]     ld_reg,
    input  logic [$clog2(MVL)-1:0]       ld_idx,
    input  logic [31:0]                  ld_data,
    input  logic [$clog2(NREGS)-1:0]     peek_reg,
    input  logic [$clog2(MVL)-1:0]       peek_idx,
    output logic [31:0]                  peek_data,
    output logic                         busy,
    output logic                         chain_valid,
    output logic [$clog2(NREGS)-1:0]     chain_dst,
    output logic [$clog2(MVL)-1:0]       chain_base,
    output logic [LANES-1:0]             chain_en,
    output logic [LANES*32-1:0]          chain_data
);
    localparam int W  = vle_pkg::ELEM_W;
    localparam int RW = $clog2(NREGS);
    localparam int IW = $clog2(MVL);

    logic                 seq_active, g_form;
    vle_pkg::vop_e        g_op;
    logic [IW-1:0]        g_base;
    logic [RW-1:0]        g_sa, g_sb, g_dst;
    logic [W-1:0]         g_scalar;
    logic [LANES-1:0]     g_en;
    logic [W-1:0]         opa [LANES];
    logic [W-1:0]         opb [LANES];
    logic [W-1:0]         res [LANES];

    logic [LAT-1:0]       ctl_v;
    logic [IW-1:0]        ctl_base [LAT];
    logic [RW-1:0]        ctl_dst  [LAT];
    logic [LANES-1:0]     ctl_en   [LAT];

    vle_seq #(.MVL(MVL), .LANES(LANES), .NREGS(NREGS), .W(W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .vl_we(vl_we), .vl_wdata(vl_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .iss_valid(iss_valid), .iss_op(vle_pkg::vop_e'(iss_op)),
        .iss_form(iss_form), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_dst(iss_dst), .iss_scalar(iss_scalar),
        .pipe_busy(|ctl_v), .active(seq_active),
        .g_base(g_base), .g_op(g_op), .g_form(g_form),
        .g_sa(g_sa), .g_sb(g_sb), .g_dst(g_dst),
        .g_scalar(g_scalar), .g_en(g_en)
    );

    vle_regfile #(.NREGS(NREGS), .MVL(MVL), .LANES(LANES), .W(W)) u_rf (
        .clk(clk),
        .ra_reg(g_sa), .rb_reg(g_sb), .rd_base(g_base),
        .ra_data(opa), .rb_data(opb),
        .wb_valid(chain_valid), .wb_reg(chain_dst), .wb_base(chain_base),
        .wb_en(chain_en), .wb_data(res),
        .ld_we(ld_we), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
        .peek_reg(peek_reg), .peek_idx(peek_idx), .peek_data(peek_data)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vle_lane #(.W(W), .LAT(LAT)) u_lane (
            .clk(clk),
            .in_op(g_op),
            .in_a(opa[l]),
            .in_b(g_form ? g_scalar : opb[l]),
            .out_res(res[l])
        );
        assign chain_data[l*W +: W] = res[l];
    end

    // Group-valid pipeline alongside the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_v <= '0;
        end else begin
            ctl_v[0] <= seq_active;
            for (int s = 1; s < LAT; s++) ctl_v[s] <= ctl_v[s-1];
        end
    end

    // Group address and enables travelling with the lane data.
    always_ff @(posedge clk) begin
        ctl_base[0] <= g_base;
        ctl_dst[0]  <= g_dst;
        ctl_en[0]   <= g_en;
        for (int s = 1; s < LAT; s++) begin
            ctl_base[s] <= ctl_base[s-1];
            ctl_dst[s]  <= ctl_dst[s-1];
            ctl_en[s]   <= ctl_en[s-1];
        end
    end

    assign chain_valid = ctl_v[LAT-1];
    assign chain_base  = ctl_base[LAT-1];
    assign chain_dst   = ctl_dst[LAT-1];
    assign chain_en    = ctl_v[LAT-1] ? ctl_en[LAT-1] : '0;
    assign busy        = seq_active | (|ctl_v);
endmodule

// File: rtl/vle_checker.sv
// Protocol checker for the vector lane engine, bound to the top.
// Watches issue, busy and the forwarding port only.
module vle_checker #(
    parameter int LANES = 2,
    parameter int IW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             busy,
    input logic             chain_valid,
    input logic [IW-1:0]    chain_base,
    input logic [LANES-1:0] chain_en
);
    // R5: an accepted instruction makes the unit busy next cycle.
    a_r5_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !busy |=> busy);

    // R8: an idle unit with no instruction stays idle.
    a_r8_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !iss_valid |=> !busy);

    // R7: no write flag without a forwarded group.
    a_r7_en_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_valid |-> chain_en == '0);

    // R4: the first group of an instruction starts at element 0.
    a_r4_first_base: assert property (@(posedge clk) disable iff (!rst_n)
        chain_valid && !$past(chain_valid) |-> chain_base == '0);

    // R4: back-to-back groups advance by LANES elements.
    a_r4_stride: assert property (@(posedge clk) disable iff (!rst_n)
        chain_valid && $past(chain_valid) |-> chain_base == $past(chain_base) + IW'(LANES));
endmodule

bind vec_lane_engine vle_checker #(.LANES(LANES), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .busy(busy),
    .chain_valid(chain_valid), .chain_base(chain_base), .chain_en(chain_en)
);

// File: tb/vec_lane_engine_test.sv
`timescale 1ns/1ps
// Directed bench for the vector lane engine: one task per scenario,
// cycle-exact checks of busy and the forwarding port, and a full
// register file comparison against a model after each instruction.
module vec_lane_engine_test;
    localparam int MVL = 8, L = 2, NR = 8, LAT = 3;
    localparam int RW = $clog2(NR), IW = $clog2(MVL), VLW = $clog2(MVL+1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic iss_valid = 0, iss_op = 0, iss_form = 0;
    logic [RW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [31:0] iss_scalar = '0;
    logic vl_we = 0, mask_we = 0, ld_we = 0;
    logic [VLW-1:0] vl_wdata = '0;
    logic [MVL-1:0] mask_wdata = '0;
    logic [RW-1:0] ld_reg = '0, peek_reg = '0;
    logic [IW-1:0] ld_idx = '0, peek_idx = '0;
    logic [31:0] ld_data = '0, peek_data;
    logic busy, chain_valid;
    logic [RW-1:0] chain_dst;
    logic [IW-1:0] chain_base;
    logic [L-1:0] chain_en;
    logic [L*32-1:0] chain_data;

    int checks = 0, fails = 0;
    logic [31:0] m_rf [NR][MVL];
    int m_vl = MVL;
    logic [MVL-1:0] m_mask = '1;

    always #10 clk = ~clk;

    vec_lane_engine #(.MVL(MVL), .LANES(L), .NREGS(NR), .LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_form(iss_form), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_dst(iss_dst), .iss_scalar(iss_scalar), .vl_we(vl_we),
        .vl_wdata(vl_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ld_we(ld_we), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
        .peek_reg(peek_reg), .peek_idx(peek_idx), .peek_data(peek_data),
        .busy(busy), .chain_valid(chain_valid), .chain_dst(chain_dst),
        .chain_base(chain_base), .chain_en(chain_en), .chain_data(chain_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] calc(input bit op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        p = {32'd0, a} * {32'd0, b};
        return op ? p[31:0] : a + b;
    endfunction

    task automatic load_all();
        for (int r = 0; r < NR; r++) begin
            for (int i = 0; i < MVL; i++) begin
                @(negedge clk);
                m_rf[r][i] = 32'h9E37_79B9 * 32'(r * MVL + i + 1) + 32'(r);
                ld_we = 1; ld_reg = RW'(r); ld_idx = IW'(i); ld_data = m_rf[r][i];
            end
        end
        @(negedge clk); ld_we = 0;
    endtask

    task automatic compare_rf(input string tag);
        @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            for (int i = 0; i < MVL; i++) begin
                peek_reg = RW'(r); peek_idx = IW'(i); #1;
                chk(peek_data === m_rf[r][i], tag, $sformatf("reg %0d elem %0d", r, i),
                    peek_data, m_rf[r][i]);
            end
        end
    endtask

    task automatic set_vl(input int v);
        @(negedge clk); vl_we = 1; vl_wdata = VLW'(v);
        @(negedge clk); vl_we = 0;
        if (v >= 1 && v <= MVL) m_vl = v;
    endtask

    task automatic set_mask(input logic [MVL-1:0] m);
        @(negedge clk); mask_we = 1; mask_wdata = m;
        @(negedge clk); mask_we = 0;
        m_mask = m;
    endtask

    // mode 0: plain; 1: extra issue while busy (R8); 2: length/mask writes while busy (R9)
    task automatic run(input string tag, input bit op, input bit form, input int sa,
                       input int sb, input int dst, input logic [31:0] scal, input int mode);
        logic [31:0] res [MVL];
        logic [MVL-1:0] en_bits;
        int ng;
        ng = (m_vl + L - 1) / L;
        for (int i = 0; i < MVL; i++) begin
            res[i] = calc(op, m_rf[sa][i], form ? scal : m_rf[sb][i]);
            en_bits[i] = (i < m_vl) && m_mask[i];
        end
        @(negedge clk);
        iss_valid = 1; iss_op = op; iss_form = form; iss_src_a = RW'(sa);
        iss_src_b = RW'(sb); iss_dst = RW'(dst); iss_scalar = scal;
        @(posedge clk);
        @(negedge clk); iss_valid = 0;
        chk(busy === 1'b1, tag, "busy after issue (R5)", 32'(busy), 1);
        for (int j = 1; j <= LAT + ng + 2; j++) begin
            bit ev;
            @(negedge clk);
            iss_valid = 0; vl_we = 0; mask_we = 0;
            chk(busy === (j < LAT + ng), tag, $sformatf("busy cycle %0d (R5)", j),
                32'(busy), 32'(j < LAT + ng));
            ev = (j >= LAT) && (j < LAT + ng);
            chk(chain_valid === ev, tag, $sformatf("chain_valid cycle %0d (R4)", j),
                32'(chain_valid), 32'(ev));
            if (ev) begin
                int k;
                k = j - LAT;
                chk(chain_base === IW'(k * L), tag, "chain_base (R4)", 32'(chain_base), 32'(k * L));
                chk(chain_dst === RW'(dst), tag, "chain_dst (R4)", 32'(chain_dst), 32'(dst));
                for (int l = 0; l < L; l++) begin
                    int e;
                    e = k * L + l;
                    chk(chain_en[l] === en_bits[e], tag, $sformatf("chain_en elem %0d (R7)", e),
                        32'(chain_en[l]), 32'(en_bits[e]));
                    if (en_bits[e])
                        chk(chain_data[l*32 +: 32] === res[e], tag,
                            $sformatf("chain_data elem %0d", e), chain_data[l*32 +: 32], res[e]);
                end
            end
            if (j == 2 && mode == 1) begin
                iss_valid = 1; iss_op = 0; iss_form = 0; iss_src_a = 0;
                iss_src_b = 0; iss_dst = RW'(7);
            end
            if (j == 2 && mode == 2) begin
                vl_we = 1; vl_wdata = VLW'(3); mask_we = 1; mask_wdata = 8'h0F;
            end
        end
        iss_valid = 0; vl_we = 0; mask_we = 0;
        for (int i = 0; i < MVL; i++) if (en_bits[i]) m_rf[dst][i] = res[i];
        if (mode == 2) begin m_vl = 3; m_mask = 8'h0F; end
        compare_rf(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy === 1'b0, "R1", "busy at reset", 32'(busy), 0);
        chk(chain_valid === 1'b0, "R1", "chain_valid at reset", 32'(chain_valid), 0);
        chk(chain_en === '0, "R1", "chain_en at reset", 32'(chain_en), 0);
    endtask

    initial begin : watchdog
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        load_all();
        run("R1 R2 add", 0, 0, 1, 2, 3, 32'h0, 0);
        run("R2 mul", 1, 0, 4, 5, 6, 32'h0, 0);
        run("R3 add", 0, 1, 1, 0, 0, 32'hFFFF_FFF0, 0);
        run("R3 mul", 1, 1, 2, 0, 5, 32'h0001_0001, 0);
        set_vl(5);
        run("R6 len5", 0, 0, 3, 6, 7, 32'h0, 0);
        set_vl(0);
        set_vl(9);
        run("R6 ignored", 1, 0, 7, 1, 2, 32'h0, 0);
        set_vl(8);
        set_mask(8'b1011_0010);
        run("R7 mask", 0, 0, 0, 1, 4, 32'h0, 0);
        set_mask('1);
        run("R8 busy drop", 1, 1, 3, 0, 1, 32'h0000_0007, 1);
        run("R9 snapshot", 0, 0, 2, 3, 0, 32'h0, 2);
        run("R9 R10 in place", 0, 0, 4, 4, 4, 32'h0, 0);
        set_mask('1);
        set_vl(1);
        run("R6 len1", 1, 1, 6, 0, 6, 32'h8000_0001, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule